// File: doc/BRIEF.md
# Paced Serial Command Transmitter

This block sends 16-bit command words out over a slow asynchronous serial line. The host bus writes words into a 40-entry write queue, and each write gets an immediate accept flag (Q) back. A sequencer takes one word at a time from the queue. It pads the word to 18 bits with two leading zero bits and cuts it into three 6-bit characters, sending the most significant character first.

Each character goes out as one asynchronous frame of eleven bits, in this order:

- a low start bit;
- the six data bits, least significant first;
- a word-framing flag bit;
- an odd parity bit;
- two high stop bits.

The far end is slow. After every character the line therefore stays at mark for a programmable number of clocks before the next start bit. The bit period and that gap are parameters. The defaults give 2400 baud and a 100 ms gap from a 100 MHz clock. A clear strobe empties the queue and drops the word that is being sent.

Top module: `cmd_serial_tx`

## Requirements
- R1: A word w is sent as three characters in this order: {2'b00, w[15:12]}, then w[11:6], then w[5:0].
- R2: Each character frame on txd_o lasts 11 bit periods of CLKS_PER_BIT clocks each. The bits are: a start bit of 0, data bits 0 to 5 (LSB first), the flag bit, the parity bit, and two stop bits of 1.
- R3: The flag bit is 1 on the first character of a word and 0 on the second and third.
- R4: The parity bit makes the count of ones over the six data bits, the flag and the parity bit odd.
- R5: txd_o rests at 1 (mark) whenever no frame is being sent, including during the gap.
- R6: After the second stop bit of every character, at least GAP_CLKS clocks pass before the next start bit. Within one word, start bits are at least 11*CLKS_PER_BIT+GAP_CLKS clocks apart and at most 4 clocks more than that.
- R7: The queue holds DEPTH (40) words and sends them in write order. In the same cycle as wr_en_i, wr_q_o is 1 exactly when the word is accepted, which means the queue is not full and clr_i is low. A rejected word is never sent.
- R8: A clr_i pulse empties the queue and drops the word in progress. txd_o is 1 from the next cycle on, and nothing more is sent until a new word is written.
- R9: After reset the queue is empty and txd_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Clear strobe: empties the queue and aborts the current word |
| wr_en_i | input | 1 | Bus write strobe for a command word |
| wr_data_i | input | 16 | Command word to queue |
| wr_q_o | output | 1 | Accept response, valid in the same cycle as wr_en_i |
| txd_o | output | 1 | Serial output, idle at 1 |

## Verification
The bound checker checks these rules on every cycle:

- no accept while the queue is full, and the occupancy never goes past DEPTH;
- the queue is empty and the line is at mark right after a clear;
- the line stays at mark through every gap;
- a frame start always drives the line low;
- each new frame follows a long enough run of mark.

Only the bench scenarios can show the content of the characters: how a word is split, the flag placement, the parity value, and the order of words through the queue. The same goes for a burst that overflows the queue, where only the accepted words appear on the line.

// File: rtl/cmd_tx_pkg.sv
package cmd_tx_pkg;
  localparam int unsigned WORD_W         = 16;
  localparam int unsigned CHAR_W         = 6;
  localparam int unsigned CHARS_PER_WORD = 3;
  localparam int unsigned FRAME_W        = 1 + CHAR_W + 1 + 1 + 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SEND, SQ_GAP} seq_state_e;

  // word padded to 18 bits, most significant character first
  function automatic logic [CHAR_W-1:0] pick_char(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] idx);
    logic [CHAR_W*CHARS_PER_WORD-1:0] p;
    p = {2'b00, w};
    case (idx)
      2'd0:    return p[17:12];
      2'd1:    return p[11:6];
      default: return p[5:0];
    endcase
  endfunction

  // LSB leaves first: start, data, flag, odd parity, two stops
  function automatic logic [FRAME_W-1:0] build_frame(input logic [CHAR_W-1:0] d,
                                                     input logic flag);
    logic par;
    par = ~(^{flag, d});
    return {2'b11, par, flag, d, 1'b0};
  endfunction
endpackage

// File: rtl/cmd_tx_fifo.sv
module cmd_tx_fifo #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 40,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_ok_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic              push, pop;

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_ok_o   = (cnt != CNT_W'(DEPTH)) && !clr_i;
  assign push      = wr_en_i && wr_ok_o;
  assign empty_o   = (cnt == '0);
  assign pop       = rd_en_i && !empty_o && !clr_i;
  assign rd_data_o = mem[rd_ptr];
  assign count_o   = cnt;

  always_ff @(posedge clk_i) begin
    if (push) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cmd_tx_shifter.sv
module cmd_tx_shifter #(
  parameter int unsigned CLKS_PER_BIT = 41667,
  parameter int unsigned FRAME_W      = 11,
  localparam int unsigned BAUD_W      = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1,
  localparam int unsigned BIT_W       = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               abort_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               done_o,
  output logic               txd_o
);
  logic [FRAME_W-1:0] sh;
  logic [BAUD_W-1:0]  baud_cnt;
  logic [BIT_W-1:0]   bit_cnt;
  logic               busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh       <= '1;
      baud_cnt <= '0;
      bit_cnt  <= '0;
      busy     <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (abort_i) begin
        sh   <= '1;
        busy <= 1'b0;
      end else if (start_i && !busy) begin
        sh       <= frame_i;
        busy     <= 1'b1;
        baud_cnt <= '0;
        bit_cnt  <= '0;
      end else if (busy) begin
        if (baud_cnt == BAUD_W'(CLKS_PER_BIT - 1)) begin
          baud_cnt <= '0;
          sh       <= {1'b1, sh[FRAME_W-1:1]};
          if (bit_cnt == BIT_W'(FRAME_W - 1)) begin
            busy   <= 1'b0;
            done_o <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          baud_cnt <= baud_cnt + 1'b1;
        end
      end
    end
  end

  assign txd_o = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/cmd_tx_pacer.sv
module cmd_tx_pacer
  import cmd_tx_pkg::*;
#(
  parameter int unsigned GAP_CLKS = 10_000_000,
  localparam int unsigned GAP_W   = (GAP_CLKS > 1) ? $clog2(GAP_CLKS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               fifo_empty_i,
  input  logic [WORD_W-1:0]  fifo_data_i,
  output logic               fifo_pop_o,
  input  logic               tx_done_i,
  output logic               tx_start_o,
  output logic [FRAME_W-1:0] tx_frame_o,
  output logic               in_gap_o
);
  seq_state_e        state;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        idx;
  logic [GAP_W-1:0]  gap_cnt;

  assign fifo_pop_o = (state == SQ_IDLE) && !fifo_empty_i && !clr_i;
  assign tx_start_o = (state == SQ_LOAD) && !clr_i;
  assign in_gap_o   = (state == SQ_GAP);
  assign tx_frame_o = build_frame(pick_char(word_q, idx), idx == 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= SQ_IDLE;
      word_q  <= '0;
      idx     <= '0;
      gap_cnt <= '0;
    end else if (clr_i) begin
      state <= SQ_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (!fifo_empty_i) begin
          word_q <= fifo_data_i;
          idx    <= '0;
          state  <= SQ_LOAD;
        end
        SQ_LOAD: state <= SQ_SEND;
        SQ_SEND: if (tx_done_i) begin
          gap_cnt <= '0;
          state   <= SQ_GAP;
        end
        SQ_GAP: begin
          if (gap_cnt == GAP_W'(GAP_CLKS - 1)) begin
            if (idx == 2'(CHARS_PER_WORD - 1)) begin
              state <= SQ_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_LOAD;
            end
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_serial_tx.sv
module cmd_serial_tx
  import cmd_tx_pkg::*;
#(
  parameter int unsigned DEPTH        = 40,
  parameter int unsigned CLKS_PER_BIT = 41667,
  parameter int unsigned GAP_CLKS     = 10_000_000,
  localparam int unsigned CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        wr_en_i,
  input  logic [15:0] wr_data_i,
  output logic        wr_q_o,
  output logic        txd_o
);
  logic               fifo_wr_ok, fifo_empty, fifo_pop;
  logic [WORD_W-1:0]  fifo_data;
  logic [CNT_W-1:0]   fifo_cnt;
  logic               tx_start, tx_done, in_gap;
  logic [FRAME_W-1:0] tx_frame;

  assign wr_q_o = wr_en_i && fifo_wr_ok;

  cmd_tx_fifo #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .wr_ok_o   (fifo_wr_ok),
    .rd_en_i   (fifo_pop),
    .rd_data_o (fifo_data),
    .empty_o   (fifo_empty),
    .count_o   (fifo_cnt)
  );

  cmd_tx_pacer #(.GAP_CLKS(GAP_CLKS)) u_pacer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr_i),
    .fifo_empty_i (fifo_empty),
    .fifo_data_i  (fifo_data),
    .fifo_pop_o   (fifo_pop),
    .tx_done_i    (tx_done),
    .tx_start_o   (tx_start),
    .tx_frame_o   (tx_frame),
    .in_gap_o     (in_gap)
  );

  cmd_tx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT), .FRAME_W(FRAME_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .abort_i (clr_i),
    .start_i (tx_start),
    .frame_i (tx_frame),
    .done_o  (tx_done),
    .txd_o   (txd_o)
  );
endmodule

// File: rtl/cmd_tx_checker.sv
module cmd_tx_checker #(
  parameter int unsigned DEPTH        = 40,
  parameter int unsigned CLKS_PER_BIT = 41667,
  parameter int unsigned GAP_CLKS     = 10_000_000,
  localparam int unsigned CNT_W       = $clog2(DEPTH + 1),
  localparam int unsigned IDLE_MIN    = 2 * CLKS_PER_BIT + GAP_CLKS,
  localparam int unsigned RUN_W       = $clog2(IDLE_MIN + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             wr_q_o,
  input logic             txd_o,
  input logic [CNT_W-1:0] fifo_cnt_i,
  input logic             tx_start_i,
  input logic             in_gap_i
);
  logic [RUN_W-1:0] idle_run;
  logic             seen_frame;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_run   <= '0;
      seen_frame <= 1'b0;
    end else begin
      if (!txd_o)                          idle_run <= '0;
      else if (idle_run != RUN_W'(IDLE_MIN)) idle_run <= idle_run + 1'b1;
      if (clr_i)           seen_frame <= 1'b0;
      else if (tx_start_i) seen_frame <= 1'b1;
    end
  end

  p_no_accept_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i == CNT_W'(DEPTH) |-> !wr_q_o);
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt_i <= CNT_W'(DEPTH));
  p_clear_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> fifo_cnt_i == '0);
  p_clear_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> txd_o);
  p_gap_mark_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_gap_i |-> txd_o);
  p_gap_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_i && seen_frame) |-> idle_run >= RUN_W'(IDLE_MIN));
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !txd_o);
endmodule

bind cmd_serial_tx cmd_tx_checker #(
  .DEPTH(DEPTH), .CLKS_PER_BIT(CLKS_PER_BIT), .GAP_CLKS(GAP_CLKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .wr_q_o     (wr_q_o),
  .txd_o      (txd_o),
  .fifo_cnt_i (fifo_cnt),
  .tx_start_i (tx_start),
  .in_gap_i   (in_gap)
);

// File: tb/cmd_serial_tx_tb.sv
module cmd_serial_tx_tb_top;
  localparam int CPB   = 4;
  localparam int GAP   = 20;
  localparam int DEPTH = 40;
  localparam int SPACE = 11 * CPB + GAP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        wr_q;
  logic        txd;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  int rx_frames = 0;
  bit skip_gap = 1'b1;
  logic [6:0] exp_q[$];   // {flag, data}

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_serial_tx #(.DEPTH(DEPTH), .CLKS_PER_BIT(CPB), .GAP_CLKS(GAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_q_o(wr_q), .txd_o(txd));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_char(input logic [15:0] w, input int i);
    logic [17:0] p = {2'b00, w};
    return p[17 - 6*i -: 6];
  endfunction

  task automatic push_exp(input logic [15:0] w);
    for (int i = 0; i < 3; i++) exp_q.push_back({(i == 0), exp_char(w, i)});
  endtask

  task automatic write_word(input logic [15:0] w, output bit q);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    #1 q = wr_q;
    if (q) push_exp(w);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 30000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, "R7", "all accepted chars sent", exp_q.size(), 0);
    repeat (3 * SPACE) @(negedge clk);
  endtask

  // line monitor
  initial begin
    logic [10:0] b;
    logic [6:0]  e;
    int unsigned t0, prev;
    prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n && !txd) begin
        t0 = cyc;
        repeat (CPB / 2) @(negedge clk);
        b[0] = txd;
        for (int k = 1; k < 11; k++) begin
          repeat (CPB) @(negedge clk);
          b[k] = txd;
        end
        chk(b[0] == 1'b0 && b[10:9] == 2'b11, "R2", "start/stop bits", b, 0);
        chk((^b[8:1]) == 1'b1, "R4", "odd parity", b[8:1], 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected frame", b, 0);
        end else begin
          e = exp_q.pop_front();
          chk(b[6:1] == e[5:0], "R1", "char data", b[6:1], e[5:0]);
          chk(b[7] == e[6], "R3", "flag bit", b[7], e[6]);
          if (!skip_gap) begin
            chk(t0 - prev >= SPACE, "R6", "min start spacing", t0 - prev, SPACE);
            if (!e[6])
              chk(t0 - prev <= SPACE + 4, "R6", "intra-word spacing", t0 - prev, SPACE);
          end
        end
        prev = t0;
        skip_gap = 1'b0;
        rx_frames++;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit q;
    int acc, base;
    logic [15:0] corner[5] = '{16'h0000, 16'hFFFF, 16'hF000, 16'h003F, 16'hA5A5};
    void'($urandom(32'h2400_5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b1, "R9", "line idle after reset", txd, 1);
    chk(rx_frames == 0, "R5", "no frames at rest", rx_frames, 0);

    // directed corner words
    write_word(corner[0], q);
    chk(q == 1'b1, "R9", "first write accepted (empty)", q, 1);
    for (int i = 1; i < 5; i++) begin
      write_word(corner[i], q);
      chk(q == 1'b1, "R7", "corner write accepted", q, 1);
    end
    drain();
    chk(txd == 1'b1, "R5", "idle after drain", txd, 1);

    // random words with random spacing
    for (int i = 0; i < 25; i++) begin
      write_word(16'($urandom), q);
      repeat ($urandom_range(0, 300)) @(negedge clk);
    end
    drain();

    // overflow burst
    acc = 0;
    for (int i = 0; i < 45; i++) begin
      write_word(16'($urandom), q);
      if (q) acc++;
      if (i < DEPTH) chk(q == 1'b1, "R7", "accept below depth", q, 1);
      if (i >= 42)   chk(q == 1'b0, "R7", "reject when full", q, 0);
    end
    chk(acc <= DEPTH + 1 && acc >= DEPTH, "R7", "accepted count", acc, DEPTH);
    drain();

    // clear during the gap after the first character
    base = rx_frames;
    write_word(16'h1357, q);
    write_word(16'h2468, q);
    write_word(16'h9ABC, q);
    while (rx_frames == base) @(negedge clk);
    repeat (CPB) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_q.delete();
    skip_gap = 1'b1;
    chk(txd == 1'b1, "R8", "mark after clear", txd, 1);
    base = rx_frames;
    repeat (8 * SPACE) @(negedge clk);
    chk(rx_frames == base, "R8", "nothing sent after clear", rx_frames, base);
    chk(txd == 1'b1, "R8", "line idle after clear", txd, 1);
    write_word(16'h1234, q);
    chk(q == 1'b1, "R8", "queue usable after clear", q, 1);
    drain();
    chk(rx_frames == base + 3, "R8", "new word sent after clear", rx_frames, base + 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule